// File: doc/BRIEF.md
# Host Indirect Memory Write Port

This block is a slave port through which an external host writes words into a processor's on-chip program memory and data memory. The host uses one shared 16-bit address/data bus and a set of handshake lines. These are an active-low select, an active-low write strobe, an active-low read strobe, an active-high address-latch strobe, and an active-low acknowledge that the port drives. An address-latch cycle loads a memory-select bit and a word address into the port's control register. After that, each write cycle stores the bus data at the current address, and the address then steps by one.

Data-memory words are 16 bits and need one bus write. Program-memory words are 24 bits and need two bus writes. The first write carries the upper 16 bits and goes into a holding latch. The port acknowledges it at once and does not touch memory. The second write supplies the low byte and launches the internal memory write. The pending upper half is dropped in two cases: a new address-latch cycle, or a processor-side control-register write, arriving before the second half. In either case memory is left unchanged.

The host may run a long write, where it waits for acknowledge to fall before releasing its strobes. It may also run a short write, where it releases the strobes first and the port captures the bus at that release. The internal memory is reached through a single-cycle request pulse that carries address, data and memory select, and it answers with a single-cycle done pulse.

Top module: `hwp_port`

## Requirements
- R1: After reset, acknowledge is low, no memory request is issued, and the control register selects data memory (select bit 0) at address 0.
- R2: When select and write strobe are both low while the port is idle, acknowledge goes high within 10 clock cycles.
- R3: In a long write, the port captures the bus data while the strobes are still low, and then drops acknowledge. The captured value is the one written to memory.
- R4: In a short write, the port captures the bus data when it sees select and write strobe back high. That value is written to memory.
- R5: A write cycle is not started while the address-latch strobe is high or the read strobe is low. Acknowledge stays low and no memory request follows.
- R6: The first write to program memory produces no memory request. Acknowledge returns low once the half-word is in the holding latch.
- R7: The second program-memory write issues one request with the program select set to 1. Its data is {first transfer[15:0], second transfer[7:0]}, and bits 15:8 of the second transfer are ignored.
- R8: After a data-memory write or a second program-memory write, acknowledge stays high until the memory's done pulse has been received.
- R9: An address-latch cycle or a control-register write between the two program-memory halves discards the pending half. The discard issues no request, and the next pair is assembled from scratch at the newly selected address.
- R10: The address increments by one, wrapping at 14 bits, after every completed word write.
- R11: On the falling edge of the address-latch strobe, bus bit 14 is loaded as the memory select (1 = program memory) and bits 13:0 are loaded as the address. A control-register write loads its select and address fields directly.
- R12: Each memory request is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_sel_n | input | 1 | Host select, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_rd_n | input | 1 | Host read strobe, active low (only qualifies writes) |
| hst_ale | input | 1 | Host address-latch strobe, active high |
| hst_ad | input | 16 | Multiplexed address/data bus |
| hst_ack_n | output | 1 | Acknowledge, low when the port is ready |
| cfg_wr | input | 1 | Processor-side control-register write strobe |
| cfg_pm | input | 1 | Memory select written by cfg_wr (1 = program memory) |
| cfg_addr | input | 14 | Address written by cfg_wr |
| mw_req | output | 1 | Internal memory write request pulse |
| mw_pm | output | 1 | Request targets program memory |
| mw_addr | output | 14 | Request word address |
| mw_data | output | 24 | Request data (data-memory words zero-extended) |
| mw_done | input | 1 | Internal write completed pulse |

## Verification
A holding latch that is not cleared shows up on the next program-memory pair as a request in the wrong place: either a request fires after only one transfer, or the assembled upper half is stale. The mismatch is visible on the request port in the cycle of that pair's second write. An address register that slips or misses a load appears as a wrong request address on the very next word. A handshake phase that is stuck either holds acknowledge high past the done pulse or drops it while memory is still busy, and both are seen at acknowledge within a few cycles.

// File: rtl/hwp_pkg.sv
// Shared types for the host write port.
// Assumes nothing beyond being compiled before the modules that import it.
package hwp_pkg;
    // Handshake phase of one host write transfer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // ready, acknowledge low
        PH_WAIT = 2'd1,   // write recognised, waiting for bus data
        PH_MEM  = 2'd2,   // internal memory write outstanding
        PH_REL  = 2'd3    // acknowledge low, waiting for host strobe release
    } phase_t;
endpackage

// File: rtl/hwp_sync.sv
// Multi-stage synchroniser for asynchronous host strobes.
// Assumes each bit is an independent level; reset value is per bit.
module hwp_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hwp_addr_reg.sv
// Control register: memory select and word address.
// Loaded by an address-latch cycle (bus sampled at strobe fall) or by a
// processor-side write (which wins); steps by one after each finished word.
// Assumes the bus still holds the address when the synchronised strobe falls.
module hwp_addr_reg #(
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_s,
    input  logic [BUS_W-1:0]  bus,
    input  logic              cfg_wr,
    input  logic              cfg_pm,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              word_done,
    output logic              cur_pm,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              discard
);
    logic ale_q;
    logic ale_fall;

    assign ale_fall = ale_q && !ale_s;
    assign discard  = ale_fall || cfg_wr;

    // Track the previous synchronised latch strobe for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ale_q <= 1'b0;
        else        ale_q <= ale_s;
    end

    // Load or advance the select and address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pm   <= 1'b0;
            cur_addr <= '0;
        end else if (cfg_wr) begin
            cur_pm   <= cfg_pm;
            cur_addr <= cfg_addr;
        end else if (ale_fall) begin
            cur_pm   <= bus[ADDR_W];
            cur_addr <= bus[ADDR_W-1:0];
        end else if (word_done) begin
            cur_addr <= cur_addr + 1'b1;
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !discard) |=> (cur_addr == $past(cur_addr) + 1'b1)) else $error("addr step"); // R10
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_fall && !cfg_wr) |=> (cur_pm == $past(bus[ADDR_W]) && cur_addr == $past(bus[ADDR_W-1:0]))) else $error("latch load"); // R11
endmodule

// File: rtl/hwp_cycle_fsm.sv
// Host write handshake, program-word holding latch and memory request.
// A write starts on synchronised select+write low (latch strobe low, read
// strobe high). Data is captured on strobe release (short cycle) or after
// DATA_WAIT cycles with strobes still low (long cycle). Assumes the host
// keeps the bus valid across the capture point.
module hwp_cycle_fsm
    import hwp_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int LOW_W     = 8,
    parameter int ADDR_W    = 14,
    parameter int DATA_WAIT = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n_s,
    input  logic                    wr_n_s,
    input  logic                    rd_n_s,
    input  logic                    ale_s,
    input  logic [BUS_W-1:0]        bus,
    input  logic                    discard,
    input  logic                    cur_pm,
    input  logic [ADDR_W-1:0]       cur_addr,
    input  logic                    mem_done,
    output logic                    ack_n,
    output logic                    mem_req,
    output logic                    mem_pm,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BUS_W+LOW_W-1:0]  mem_data,
    output logic                    word_done
);
    localparam int WORD_W = BUS_W + LOW_W;
    localparam int CNT_W  = $clog2(DATA_WAIT + 1);

    phase_t           ph, ph_nxt;
    logic [CNT_W-1:0] cnt;
    logic [BUS_W-1:0] hold;
    logic             hold_v;
    logic             wr_act, qualified, capture, first_half;

    // Decode host strobe levels and the next handshake phase
    always_comb begin
        wr_act     = !sel_n_s && !wr_n_s;
        qualified  = wr_act && !ale_s && rd_n_s;
        capture    = (ph == PH_WAIT) && (!wr_act || cnt == CNT_W'(DATA_WAIT - 1));
        first_half = cur_pm && !hold_v;
        word_done  = (ph == PH_MEM) && mem_done;
        ph_nxt     = ph;
        unique case (ph)
            PH_IDLE: if (qualified) ph_nxt = PH_WAIT;
            PH_WAIT: if (capture)   ph_nxt = first_half ? (wr_act ? PH_REL : PH_IDLE) : PH_MEM;
            PH_MEM:  if (mem_done)  ph_nxt = wr_act ? PH_REL : PH_IDLE;
            PH_REL:  if (!wr_act)   ph_nxt = PH_IDLE;
            default: ph_nxt = PH_IDLE;
        endcase
    end

    // Phase register, data-wait counter and registered acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            ack_n <= 1'b0;
        end else begin
            ph    <= ph_nxt;
            cnt   <= (ph == PH_WAIT && !capture) ? cnt + 1'b1 : '0;
            ack_n <= (ph_nxt == PH_WAIT) || (ph_nxt == PH_MEM);
        end
    end

    // Holding latch for the upper half of a program word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= '0;
            hold_v <= 1'b0;
        end else if (discard) begin
            hold_v <= 1'b0;
        end else if (capture) begin
            if (first_half) begin
                hold   <= bus;
                hold_v <= 1'b1;
            end else begin
                hold_v <= 1'b0;
            end
        end
    end

    // Internal memory write request with its address, select and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_pm   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            mem_req <= capture && !first_half;
            if (capture && !first_half) begin
                mem_pm   <= cur_pm;
                mem_addr <= cur_addr;
                mem_data <= cur_pm ? {hold, bus[LOW_W-1:0]} : WORD_W'(bus);
            end
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req) else $error("req pulse"); // R12
    AST_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || (ph == PH_MEM && !mem_done)) |=> ack_n) else $error("ack busy"); // R8
    AST_FIRST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_v) |-> !mem_req) else $error("first half req"); // R6
    AST_QUALIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IDLE && (ale_s || !rd_n_s)) |=> (ph != PH_WAIT)) else $error("qualify"); // R5
    AST_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> !hold_v) else $error("discard"); // R9
endmodule

// File: rtl/hwp_port.sv
// Host indirect memory write port, top level.
// Synchronises host strobes, keeps the control register and runs the write
// handshake toward a request/done internal memory interface.
// Assumes BUS_W > ADDR_W (bus bit ADDR_W carries the memory select).
module hwp_port #(
    parameter int BUS_W       = 16,
    parameter int LOW_W       = 8,
    parameter int ADDR_W      = 14,
    parameter int DATA_WAIT   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hst_sel_n,
    input  logic                   hst_wr_n,
    input  logic                   hst_rd_n,
    input  logic                   hst_ale,
    input  logic [BUS_W-1:0]       hst_ad,
    output logic                   hst_ack_n,
    input  logic                   cfg_wr,
    input  logic                   cfg_pm,
    input  logic [ADDR_W-1:0]      cfg_addr,
    output logic                   mw_req,
    output logic                   mw_pm,
    output logic [ADDR_W-1:0]      mw_addr,
    output logic [BUS_W+LOW_W-1:0] mw_data,
    input  logic                   mw_done
);
    logic [3:0]        strb_s;
    logic              discard, cur_pm, word_done;
    logic [ADDR_W-1:0] cur_addr;

    hwp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({hst_ale, hst_rd_n, hst_wr_n, hst_sel_n}),
        .q(strb_s)
    );

    hwp_addr_reg #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .ale_s(strb_s[3]), .bus(hst_ad),
        .cfg_wr(cfg_wr), .cfg_pm(cfg_pm), .cfg_addr(cfg_addr),
        .word_done(word_done), .cur_pm(cur_pm), .cur_addr(cur_addr),
        .discard(discard)
    );

    hwp_cycle_fsm #(.BUS_W(BUS_W), .LOW_W(LOW_W), .ADDR_W(ADDR_W),
                    .DATA_WAIT(DATA_WAIT)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sel_n_s(strb_s[0]), .wr_n_s(strb_s[1]), .rd_n_s(strb_s[2]),
        .ale_s(strb_s[3]), .bus(hst_ad), .discard(discard),
        .cur_pm(cur_pm), .cur_addr(cur_addr), .mem_done(mw_done),
        .ack_n(hst_ack_n), .mem_req(mw_req), .mem_pm(mw_pm),
        .mem_addr(mw_addr), .mem_data(mw_data), .word_done(word_done)
    );

    AST_RESET_ACK: assert property (@(posedge clk)
        !rst_n |=> (!hst_ack_n && !mw_req)) else $error("reset state"); // R1
endmodule

// File: tb/tb_hwp_port.sv
module tb_hwp_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_sel_n = 1'b1, hst_wr_n = 1'b1, hst_rd_n = 1'b1, hst_ale = 1'b0;
    logic [15:0] hst_ad = '0;
    logic        hst_ack_n;
    logic        cfg_wr = 1'b0, cfg_pm = 1'b0;
    logic [13:0] cfg_addr = '0;
    logic        mw_req, mw_pm;
    logic [13:0] mw_addr;
    logic [23:0] mw_data;
    logic        mw_done = 1'b0;

    int checks = 0, failures = 0;
    int req_cnt = 0, ack_err = 0, pulse_err = 0, lat = 0;
    logic        last_pm, prev_req = 1'b0;
    logic [13:0] last_addr;
    logic [23:0] last_data;
    bit          finished = 0;

    // expected model
    logic        e_pm = 1'b0;
    logic [13:0] e_addr = '0;
    int          e_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    hwp_port dut (.*);

    // memory model and monitors, all sampled away from the active edge
    always @(negedge clk) begin
        if (lat > 0 && hst_ack_n == 1'b0) ack_err++;
        if (mw_req && prev_req) pulse_err++;
        prev_req = mw_req;
        mw_done = 1'b0;
        if (lat > 0) begin
            lat--;
            if (lat == 0) mw_done = 1'b1;
        end
        if (mw_req) begin
            req_cnt++;
            last_pm = mw_pm; last_addr = mw_addr; last_data = mw_data;
            lat = 1 + int'($urandom % 5);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ack(input logic v, input int lim, output bit ok);
        ok = 0;
        for (int i = 0; i < lim; i++) begin
            if (hst_ack_n == v) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    // address-latch cycle: bit 14 memory select, bits 13:0 address (R11)
    task automatic latch(input logic pm, input logic [13:0] a);
        @(negedge clk);
        hst_ad = {1'b0, pm, a}; hst_ale = 1'b1;
        cyc(4);
        hst_ale = 1'b0;
        cyc(5);
        e_pm = pm; e_addr = a;
    endtask

    task automatic cfg(input logic pm, input logic [13:0] a);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_pm = pm; cfg_addr = a;
        @(negedge clk);
        cfg_wr = 1'b0;
        cyc(2);
        e_pm = pm; e_addr = a;
    endtask

    // one host bus write, long or short handshake
    task automatic hwrite(input bit long_c, input logic [15:0] d);
        bit ok;
        @(negedge clk);
        hst_sel_n = 1'b0; hst_wr_n = 1'b0;
        wait_ack(1'b1, 10, ok);
        chk(ok, "R2 ack rise", {31'd0, hst_ack_n}, 32'd1);
        hst_ad = d;
        if (long_c) begin
            wait_ack(1'b0, 60, ok);
            chk(ok, "R3 long ack fall", {31'd0, hst_ack_n}, 32'd0);
            hst_sel_n = 1'b1; hst_wr_n = 1'b1;
            cyc(5);
        end else begin
            cyc(1);
            hst_sel_n = 1'b1; hst_wr_n = 1'b1;
            cyc(6);
            wait_ack(1'b0, 60, ok);
            chk(ok, "R4 short ack fall", {31'd0, hst_ack_n}, 32'd0);
            cyc(3);
        end
    endtask

    task automatic chk_req(input string tag, input logic [23:0] d);
        e_cnt++;
        chk(req_cnt == e_cnt, {tag, " count"}, req_cnt, e_cnt);
        chk(last_addr == e_addr, {tag, " addr"}, {18'd0, last_addr}, {18'd0, e_addr});
        chk(last_data == d, {tag, " data"}, {8'd0, last_data}, {8'd0, d});
        chk(last_pm == e_pm, {tag, " sel"}, {31'd0, last_pm}, {31'd0, e_pm});
        e_addr = e_addr + 14'd1;   // R10
    endtask

    task automatic dm_word(input bit long_c, input logic [15:0] d);
        hwrite(long_c, d);
        chk_req(long_c ? "R3 dm" : "R4 dm", {8'd0, d});
    endtask

    task automatic pm_word(input bit l1, input bit l2, input logic [15:0] hi, input logic [15:0] lo);
        hwrite(l1, hi);
        chk(req_cnt == e_cnt, "R6 first half no req", req_cnt, e_cnt);
        chk(hst_ack_n == 1'b0, "R6 ack low", {31'd0, hst_ack_n}, 32'd0);
        hwrite(l2, lo);
        chk_req("R7 pm", {hi, lo[7:0]});
    endtask

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk(hst_ack_n == 1'b0, "R1 ack", {31'd0, hst_ack_n}, 32'd0);
        chk(mw_req == 1'b0, "R1 req", {31'd0, mw_req}, 32'd0);
        // R1: first write without any latch goes to data memory address 0
        dm_word(1'b1, 16'hA5C3);
        dm_word(1'b0, 16'h0F1E);   // R10 address now 1
        // R5: read strobe low blocks a write
        @(negedge clk);
        hst_rd_n = 1'b0; hst_sel_n = 1'b0; hst_wr_n = 1'b0;
        cyc(12);
        chk(hst_ack_n == 1'b0, "R5 rd low ack", {31'd0, hst_ack_n}, 32'd0);
        hst_sel_n = 1'b1; hst_wr_n = 1'b1;
        cyc(5);
        hst_rd_n = 1'b1;
        cyc(3);
        chk(req_cnt == e_cnt, "R5 no req", req_cnt, e_cnt);
        // R11 latch program memory, R7 pair with upper byte ignored
        latch(1'b1, 14'h0100);
        pm_word(1'b1, 1'b1, 16'h1234, 16'hFF56);
        pm_word(1'b0, 1'b0, 16'hBEEF, 16'h0099);
        // R9 discard by address latch
        hwrite(1'b1, 16'hDEAD);
        latch(1'b1, 14'h0200);
        chk(req_cnt == e_cnt, "R9 latch discard no req", req_cnt, e_cnt);
        pm_word(1'b0, 1'b1, 16'h4321, 16'h0877);
        chk(last_addr == 14'h0200, "R9 new addr", {18'd0, last_addr}, 32'h200);
        // R9 discard by control write, R10 wrap
        hwrite(1'b0, 16'hCAFE);
        cfg(1'b0, 14'h3FFF);
        chk(req_cnt == e_cnt, "R9 cfg discard no req", req_cnt, e_cnt);
        dm_word(1'b1, 16'h7777);
        dm_word(1'b0, 16'h8888);
        chk(last_addr == 14'h0000, "R10 wrap", {18'd0, last_addr}, 32'd0);
        // random mix
        for (int it = 0; it < 30; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0)
                latch(1'($urandom), ($urandom % 2) ? 14'h3FFE : 14'($urandom));
            else if (e_pm)
                pm_word(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
            else
                dm_word(1'($urandom), 16'($urandom));
        end
        cyc(10);
        chk(ack_err == 0, "R8 ack low while busy", ack_err, 0);
        chk(pulse_err == 0, "R12 req pulse width", pulse_err, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL R2 watchdog act=%0d exp=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule